// File: doc/BRIEF.md
# Indirect Bus Access Command Bridge

This block gives a host with a 64-bit register port a path to a 32-bit on-chip peripheral bus through four registers. To write a peripheral, the host follows three steps. First it loads the data register. Next it writes a control word that holds the direction, a byte count and the downstream address. Last it polls the status register until the done flag appears. A read works the same way, except that the fetched word comes back inside the status register.

A valid control write starts a downstream request. The request is held until the bus acknowledges it, and the result is packed into status in that same cycle. Reading status hands back its value and clears it in the same access. Only one transaction can be outstanding at a time: a control write that arrives while a request is pending is dropped. A byte count above eight is refused. A refused command makes no downstream access and leaves status untouched.

Bit positions below are counted from the LSB (bit 63 is the MSB). The register is chosen by `host_addr[4:3]`: 0 is control, 1 is reset, 2 is status and 3 is data.

Top module: `ind_cmd_bridge`

## Requirements
- R1: After reset, `ds_req` is 0 and reads of status and data both return 0.
- R2: Reads of the control register (select 0) and of the reset register (select 1) return 0. Every host read returns its data with `host_rvalid` = 1 in the cycle after the request.
- R3: Writing the data register (select 3) stores `host_wdata[63:32]`. Reading it returns that value in [63:32] with zeros in [31:0].
- R4: A control write with a byte count in [59:56] of 8 or less, made while idle, raises `ds_req` in the next cycle. The request carries the fields below:
  - `ds_we` is the inverse of bit 48 (1 in bit 48 means read).
  - `ds_addr` is [31:0].
  - `ds_size` is the byte count.
  - `ds_wdata` is the data register as it was at launch.
- R5: `ds_req` stays high, with the address stable, until a cycle in which `ds_ack` is 1. In the following cycle `ds_req` is low.
- R6: A read acknowledged with `ds_err` = 0 leaves status equal to bit 11 (done) plus `ds_rdata` in [57:26], taken big-endian with byte 0 in the top byte.
- R7: A read acknowledged with `ds_err` = 1 leaves status equal to bit 11 plus all ones in [57:26].
- R8: A write that is acknowledged leaves status equal to bit 11 alone, whatever the value of `ds_err`.
- R9: A control write with a byte count above 8 raises no request and leaves status unchanged.
- R10: A host read of status (select 2) returns the stored value and clears the stored value to 0.
- R11: A control write made while `ds_req` is high is dropped. The outstanding request keeps its fields, and no second request follows it.
- R12: Host writes to the status register and to the reset register change no state.
- R13: When completion and a status read fall in the same cycle, the read returns the value from before completion and status keeps the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Host byte address; bits [4:3] select the register |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| ds_req | output | 1 | Downstream request, held until acknowledged |
| ds_we | output | 1 | Downstream direction, 1 = write |
| ds_addr | output | 32 | Downstream address |
| ds_size | output | 4 | Downstream byte count |
| ds_wdata | output | 32 | Downstream write data, big-endian |
| ds_ack | input | 1 | Downstream acknowledge |
| ds_err | input | 1 | Downstream error, sampled with the acknowledge |
| ds_rdata | input | 32 | Downstream read data, sampled with the acknowledge |

## Verification
Two functions can fall in the same cycle: loading a completion into status, and clearing status because the host reads it. To provoke this, the bench holds back the acknowledge and then drives it in the same cycle as a status read, while status still holds an earlier unread result. The bench judges the outcome with two reads. The read in the collision cycle must return the earlier result. The next read must return the new completion, which shows that the clear did not discard it.

// File: rtl/icb_pkg.sv
package icb_pkg;

  localparam int unsigned WORD_W   = 64;
  localparam int unsigned DS_W     = 32;
  localparam int unsigned SZ_W     = 4;
  // field positions, LSB-numbered
  localparam int unsigned RD_POS   = 48;
  localparam int unsigned SZ_LO    = 56;
  localparam int unsigned DONE_POS = 11;
  localparam int unsigned RDAT_LO  = 26;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic            is_read;
    logic [SZ_W-1:0] size;
    logic [DS_W-1:0] addr;
    logic [DS_W-1:0] wdata;
  } ds_cmd_t;

  function automatic logic ctl_is_read(input logic [WORD_W-1:0] ctl);
    return ctl[RD_POS];
  endfunction

  function automatic logic [SZ_W-1:0] ctl_size(input logic [WORD_W-1:0] ctl);
    return ctl[SZ_LO +: SZ_W];
  endfunction

  function automatic logic [DS_W-1:0] ctl_addr(input logic [WORD_W-1:0] ctl);
    return ctl[DS_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] stat_pack(input logic is_read,
                                                  input logic err,
                                                  input logic [DS_W-1:0] rdata);
    logic [WORD_W-1:0] s;
    s = '0;
    s[DONE_POS] = 1'b1;
    if (is_read) s[RDAT_LO +: DS_W] = err ? '1 : rdata;
    return s;
  endfunction

endpackage

// File: rtl/icb_hostregs.sv
module icb_hostregs
  import icb_pkg::*;
#(
  parameter int unsigned HOST_AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [WORD_W-1:0]  host_wdata,
  output logic [WORD_W-1:0]  host_rdata,
  output logic               host_rvalid,
  input  logic               cmp_valid,
  input  logic [WORD_W-1:0]  cmp_status,
  output logic               ctl_wr,
  output logic [WORD_W-1:0]  ctl_word,
  output logic [DS_W-1:0]    data_word,
  output logic               stat_rd,
  output logic [WORD_W-1:0]  stat_word
);

  localparam int unsigned SEL_LSB = 3;

  reg_sel_e          sel;
  logic              data_wr;
  logic [DS_W-1:0]   data_q;
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] rd_mux;

  assign sel     = reg_sel_e'(host_addr[SEL_LSB +: 2]);
  assign ctl_wr  = host_req &  host_we & (sel == SEL_CTL);
  assign data_wr = host_req &  host_we & (sel == SEL_DATA);
  assign stat_rd = host_req & ~host_we & (sel == SEL_STAT);
  assign ctl_word  = host_wdata;
  assign data_word = data_q;
  assign stat_word = stat_q;

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = stat_q;
      SEL_DATA: rd_mux = {data_q, {(WORD_W-DS_W){1'b0}}};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q      <= '0;
      stat_q      <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_req & ~host_we;
      if (host_req && !host_we) host_rdata <= rd_mux;
      if (data_wr) data_q <= host_wdata[WORD_W-1 -: DS_W];
      if (cmp_valid)    stat_q <= cmp_status;
      else if (stat_rd) stat_q <= '0;
    end
  end

endmodule

// File: rtl/icb_launcher.sv
module icb_launcher
  import icb_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [DS_W-1:0]   data_word,
  output logic              ds_req,
  output logic              ds_we,
  output logic [DS_W-1:0]   ds_addr,
  output logic [SZ_W-1:0]   ds_size,
  output logic [DS_W-1:0]   ds_wdata,
  input  logic              ds_ack,
  input  logic              ds_err,
  input  logic [DS_W-1:0]   ds_rdata,
  output logic              launch,
  output logic              reject,
  output logic              cmp_valid,
  output logic [WORD_W-1:0] cmp_status
);

  localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(MAX_BYTES);

  logic    req_q;
  ds_cmd_t cmd_q;
  logic    size_ok;

  assign size_ok   = ctl_size(ctl_word) <= SZ_MAX;
  assign launch    = ctl_wr & ~req_q &  size_ok;
  assign reject    = ctl_wr & ~req_q & ~size_ok;
  assign cmp_valid = req_q & ds_ack;
  assign cmp_status = stat_pack(cmd_q.is_read, ds_err, ds_rdata);

  assign ds_req   = req_q;
  assign ds_we    = ~cmd_q.is_read;
  assign ds_addr  = cmd_q.addr;
  assign ds_size  = cmd_q.size;
  assign ds_wdata = cmd_q.wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cmd_q <= '0;
    end else if (launch) begin
      req_q         <= 1'b1;
      cmd_q.is_read <= ctl_is_read(ctl_word);
      cmd_q.size    <= ctl_size(ctl_word);
      cmd_q.addr    <= ctl_addr(ctl_word);
      cmd_q.wdata   <= data_word;
    end else if (cmp_valid) begin
      req_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ind_cmd_bridge.sv
module ind_cmd_bridge
  import icb_pkg::*;
#(
  parameter int unsigned HOST_AW   = 5,
  parameter int unsigned MAX_BYTES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               host_rvalid,
  output logic               ds_req,
  output logic               ds_we,
  output logic [31:0]        ds_addr,
  output logic [3:0]         ds_size,
  output logic [31:0]        ds_wdata,
  input  logic               ds_ack,
  input  logic               ds_err,
  input  logic [31:0]        ds_rdata
);

  logic              ctl_wr;
  logic [WORD_W-1:0] ctl_word;
  logic [DS_W-1:0]   data_word;
  logic              stat_rd;
  logic [WORD_W-1:0] stat_word;
  logic              launch;
  logic              reject;
  logic              cmp_valid;
  logic [WORD_W-1:0] cmp_status;

  icb_hostregs #(.HOST_AW(HOST_AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .host_rvalid(host_rvalid),
    .cmp_valid  (cmp_valid),
    .cmp_status (cmp_status),
    .ctl_wr     (ctl_wr),
    .ctl_word   (ctl_word),
    .data_word  (data_word),
    .stat_rd    (stat_rd),
    .stat_word  (stat_word)
  );

  icb_launcher #(.MAX_BYTES(MAX_BYTES)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_word  (ctl_word),
    .data_word (data_word),
    .ds_req    (ds_req),
    .ds_we     (ds_we),
    .ds_addr   (ds_addr),
    .ds_size   (ds_size),
    .ds_wdata  (ds_wdata),
    .ds_ack    (ds_ack),
    .ds_err    (ds_err),
    .ds_rdata  (ds_rdata),
    .launch    (launch),
    .reject    (reject),
    .cmp_valid (cmp_valid),
    .cmp_status(cmp_status)
  );

endmodule

// File: rtl/icb_checker.sv
module icb_checker #(
  parameter int unsigned HOST_AW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_req,
  input logic               host_we,
  input logic [HOST_AW-1:0] host_addr,
  input logic [63:0]        host_wdata,
  input logic               ds_req,
  input logic               ds_we,
  input logic [31:0]        ds_addr,
  input logic               ds_ack,
  input logic               ds_err,
  input logic [31:0]        ds_rdata,
  input logic               stat_rd,
  input logic               cmp_valid,
  input logic [63:0]        stat_word
);

  logic big_ctl;
  assign big_ctl = host_req & host_we & (host_addr[4:3] == 2'd0) &
                   (host_wdata[59:56] > 4'd8);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && !ds_ack |=> ds_req && $stable(ds_addr));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && ds_ack |=> !ds_req);

  // R9
  oversize_chk: assert property (@(posedge clk) disable iff (!rst_n)
    big_ctl && !ds_req |=> !ds_req && $stable(stat_word));

  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !cmp_valid |=> stat_word == 64'd0);

  // R6
  rd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && ds_ack && !ds_we && !ds_err |=>
      stat_word[11] && stat_word[57:26] == $past(ds_rdata));

  // R8
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req && ds_ack && ds_we |=> stat_word == 64'h800);

endmodule

bind ind_cmd_bridge icb_checker #(.HOST_AW(HOST_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_req  (host_req),
  .host_we   (host_we),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .ds_req    (ds_req),
  .ds_we     (ds_we),
  .ds_addr   (ds_addr),
  .ds_ack    (ds_ack),
  .ds_err    (ds_err),
  .ds_rdata  (ds_rdata),
  .stat_rd   (stat_rd),
  .cmp_valid (cmp_valid),
  .stat_word (stat_word)
);

// File: tb/sim_ind_cmd_bridge.sv
`timescale 1ns/1ps
module sim_ind_cmd_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        host_rvalid;
  logic        ds_req, ds_we;
  logic [31:0] ds_addr, ds_wdata;
  logic [3:0]  ds_size;
  logic        ds_ack = 1'b0, ds_err = 1'b0;
  logic [31:0] ds_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  localparam logic [4:0] A_CTL = 5'h00, A_RST = 5'h08, A_STAT = 5'h10, A_DATA = 5'h18;
  localparam logic [63:0] DONE = 64'd1 << (63 - 52);

  always #4 clk = ~clk;

  ind_cmd_bridge u0 (.*);

  function automatic logic [63:0] mk_ctl(input bit rd, input int sz, input logic [31:0] a);
    logic [63:0] c;
    c = {32'd0, a};
    if (rd) c = c | (64'd1 << (63 - 15));
    c = c | (64'(sz & 15) << (63 - 7));
    return c;
  endfunction

  function automatic logic [63:0] exp_rd(input bit err, input logic [31:0] d);
    return DONE | (64'(err ? 32'hFFFF_FFFF : d) << (63 - 37));
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [63:0] d);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    host_req = 0;
    d = host_rdata;
    check("R2 rvalid", 64'(host_rvalid), 64'd1);
  endtask

  task automatic serve(input int lat, input bit err, input logic [31:0] d);
    for (int i = 0; i < lat; i++) @(negedge clk);
    ds_ack = 1; ds_err = err; ds_rdata = d;
    @(negedge clk);
    ds_ack = 0; ds_err = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] r;
    logic [31:0] rd_val, wd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    check("R1 ds_req", 64'(ds_req), 64'd0);
    hr(A_STAT, r); check("R1 status", r, 64'd0);
    hr(A_DATA, r); check("R1 data", r, 64'd0);

    // R3 / R2
    hw(A_DATA, 64'hCAFE_BABE_1111_2222);
    hr(A_DATA, r); check("R3 data", r, 64'hCAFE_BABE_0000_0000);
    hr(A_CTL, r);  check("R2 ctl reads 0", r, 64'd0);
    hr(A_RST, r);  check("R2 rst reads 0", r, 64'd0);

    // sweep of legal byte counts
    for (int s = 0; s <= 8; s++) begin
      bit rd, er;
      rd = (s % 2) == 0;
      er = (s % 3) == 0;
      wd = 32'h0BAD_F00D + 32'(s) * 32'h1111_0001;
      rd_val = 32'h1234_5678 ^ (32'(s) * 32'h0101_0101);
      hw(A_DATA, {wd, 32'h5555_5555});
      hw(A_CTL, mk_ctl(rd, s, 32'hC001_0000 + 32'(s) * 4));
      check("R4 req", 64'(ds_req), 64'd1);
      check("R4 dir", 64'(ds_we), 64'(!rd));
      check("R4 addr", 64'(ds_addr), 64'(32'hC001_0000 + 32'(s) * 4));
      check("R4 size", 64'(ds_size), 64'(s));
      if (!rd) check("R4 wdata", 64'(ds_wdata), 64'(wd));
      hw(A_DATA, 64'hFFFF_FFFF_0000_0000);
      if (!rd) check("R4 wdata latched", 64'(ds_wdata), 64'(wd));
      for (int k = 0; k < s % 3; k++) begin
        @(negedge clk);
        check("R5 held", 64'(ds_req), 64'd1);
      end
      serve(0, er, rd_val);
      check("R5 released", 64'(ds_req), 64'd0);
      hr(A_STAT, r);
      if (rd && !er) check("R6 read ok", r, exp_rd(0, rd_val));
      else if (rd)   check("R7 read err", r, exp_rd(1, rd_val));
      else           check("R8 write done", r, DONE);
      hr(A_STAT, r); check("R10 cleared", r, 64'd0);
    end

    // oversize counts
    for (int s = 9; s <= 15; s++) begin
      hw(A_CTL, mk_ctl(0, 4, 32'h100));
      serve(0, 1, 32'h0);
      hw(A_CTL, mk_ctl(s % 2, s, 32'h2000 + 32'(s)));
      check("R9 no req", 64'(ds_req), 64'd0);
      @(negedge clk);
      check("R9 no req later", 64'(ds_req), 64'd0);
      hr(A_STAT, r); check("R9 status kept", r, DONE);
    end

    // R11 busy drop
    hw(A_CTL, mk_ctl(1, 4, 32'hAAAA_0000));
    hw(A_CTL, mk_ctl(0, 2, 32'hBBBB_0000));
    check("R11 addr kept", 64'(ds_addr), 64'h0000_0000_AAAA_0000);
    check("R11 dir kept", 64'(ds_we), 64'd0);
    serve(1, 0, 32'h7777_8888);
    check("R11 no second req", 64'(ds_req), 64'd0);
    @(negedge clk);
    check("R11 still idle", 64'(ds_req), 64'd0);
    hr(A_STAT, r); check("R11 result of first", r, exp_rd(0, 32'h7777_8888));

    // R12 ignored writes
    hw(A_DATA, 64'h1357_9BDF_0000_0000);
    hw(A_CTL, mk_ctl(0, 4, 32'h10));
    serve(0, 0, 32'h0);
    hw(A_STAT, 64'd0);
    hw(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R12 no req", 64'(ds_req), 64'd0);
    hr(A_DATA, r); check("R12 data kept", r, 64'h1357_9BDF_0000_0000);
    hr(A_STAT, r); check("R12 status kept", r, DONE);

    // R13 completion collides with a status read
    hw(A_CTL, mk_ctl(0, 1, 32'h40));
    serve(0, 0, 32'h0);
    hw(A_CTL, mk_ctl(1, 4, 32'h44));
    @(negedge clk);
    ds_ack = 1; ds_rdata = 32'hA1B2_C3D4;
    host_req = 1; host_we = 0; host_addr = A_STAT;
    @(negedge clk);
    ds_ack = 0; host_req = 0;
    check("R13 old value returned", host_rdata, DONE);
    hr(A_STAT, r); check("R13 new result kept", r, exp_rd(0, 32'hA1B2_C3D4));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule